// File: doc/BRIEF.md
# Generalized Bit-Reverse Permuter

This datapath unit rearranges the bits of a source word by exclusive-OR on the bit index. Result bit i is copied from source bit (i XOR k), where k is a small control value. A single k therefore selects any mix of these operations: swapping neighbouring bits, pairs, nibbles, bytes, halfwords or words, with the full reversal as the case where every bit of k is set. The control value is taken either from the low bits of a register operand or from a 6-bit immediate. A word-mode flag limits the permutation to the low half of the operand and clears the upper half.

The instruction decoder drives one operation per cycle with a valid strobe. The unit returns the permuted value in a register one cycle later. A record flag requests a three-bit signed comparison summary of the result next to it. When the flag is clear, that summary reads zero. Bit numbering is LSB-0: bit 0 is the least significant bit. Because the index mapping is an XOR over a power-of-two width, MSB-0 numbering gives the same permutation.

Top module: `grev_permuter`

## Requirements
- R1: With word_mode=0, result bit i equals source bit (i XOR k) for every i from 0 to XLEN-1, where k is log2(XLEN) bits wide and bits are numbered LSB-0.
- R2: With imm_sel=0, k is ctl_reg[log2(XLEN)-1:0]. All higher bits of ctl_reg have no effect on the result, and neither does the immediate.
- R3: With imm_sel=1, k is imm[log2(XLEN)-1:0], and ctl_reg has no effect on the result.
- R4: With word_mode=1, result bits 0 to XLEN/2-1 equal source bit (i XOR k'), where k' is the low log2(XLEN)-1 bits of the chosen control. Result bits XLEN/2 and above are zero, and source bits XLEN/2 and above have no effect.
- R5: With word_mode=1 and imm_sel=1, only imm[log2(XLEN)-2:0] is used (imm[4:0] at XLEN=64), and imm[5] has no effect.
- R6: result, out_valid and out_flags are registered. An operation presented with in_valid=1 at a rising edge appears one cycle later with out_valid=1. In a cycle after in_valid=0, out_valid is 0 and result and out_flags keep their previous values.
- R7: When the operation had record=1, out_flags is {neg, pos, zero}, with bit 2 neg, bit 1 pos and bit 0 zero, computed on the result as a signed XLEN-bit number. Exactly one of the three bits is set. When record=0, out_flags is 3'b000.
- R8: While rst_n is low, and after it is released until the first valid operation, out_valid, result and out_flags are all zero.
- R9: k=0 gives the source unchanged. k with all bits set gives the full bit reversal: result bit i equals source bit XLEN-1-i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src | input | XLEN | Source word to permute |
| ctl_reg | input | XLEN | Register control operand; only its low bits are used |
| imm | input | 6 | Immediate control field |
| imm_sel | input | 1 | 1: k from imm, 0: k from ctl_reg |
| word_mode | input | 1 | 1: permute the low half only and zero the upper half |
| record | input | 1 | 1: produce the comparison summary |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | XLEN | Registered permuted word |
| out_flags | output | 3 | {neg, pos, zero} of the result when recorded, else zero |

## Verification
The bench sweeps every k in both forms and both widths over several source patterns. It compares each result against a per-bit index model, which catches a stage wired to the wrong partner distance or a stage order that leaks bits across the wrong boundary. The register and immediate forms are driven with garbage in the unused control bits and in the other control source. A decoder that took the wrong slice, or a wrong select, would return a different permutation. Word mode is given a nonzero upper source half and imm[5] set, so an unmasked top control bit would pull upper source bits into the low half or leave data in the upper half. Zero, negative and positive results exercise each flag, and a held cycle shows whether the result register loads without a strobe.

// File: rtl/grev_pkg.sv
package grev_pkg;
  // Comparison summary carried beside a recorded result.
  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
  } rec_flags_t;

  localparam int IMM_W = 6;
endpackage

// File: rtl/grev_ctl_sel.sv
module grev_ctl_sel
  import grev_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int LG = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  ctl_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic             imm_sel,
  input  logic             word_mode,
  output logic [LG-1:0]    k
);
  logic [LG-1:0] k_raw;

  always_comb begin
    k_raw = imm_sel ? imm[LG-1:0] : ctl_reg[LG-1:0];
    k     = k_raw;
    // Word mode: the top stage would cross halves, so it is disabled.
    if (word_mode) k[LG-1] = 1'b0;
  end
endmodule

// File: rtl/grev_stage.sv
module grev_stage #(
  parameter int W = 64,
  parameter int S = 0
) (
  input  logic [W-1:0] din,
  input  logic         en,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int PARTNER = i ^ (2 ** S);
    assign dout[i] = en ? din[PARTNER] : din[i];
  end

  // A swap stage only moves bits around, so the number of ones is kept (R1).
  always_comb begin
    if (!$isunknown({din, en}))
      a_r1_stage_keeps_ones: assert ($countones(dout) == $countones(din));
  end
endmodule

// File: rtl/grev_flags.sv
module grev_flags
  import grev_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] value,
  input  logic            record,
  output rec_flags_t      flags
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (value == '0);
  assign is_neg  = value[XLEN-1];

  always_comb begin
    flags = '0;
    if (record) begin
      flags.neg  = is_neg;
      flags.zero = is_zero;
      flags.pos  = !is_neg && !is_zero;
    end
  end
endmodule

// File: rtl/grev_permuter.sv
module grev_permuter
  import grev_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  src,
  input  logic [XLEN-1:0]  ctl_reg,
  input  logic [5:0]       imm,
  input  logic             imm_sel,
  input  logic             word_mode,
  input  logic             record,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic [2:0]       out_flags
);
  localparam int LG   = $clog2(XLEN);
  localparam int HALF = XLEN / 2;

  logic [LG-1:0]   k;
  logic [XLEN-1:0] src_eff;
  logic [XLEN-1:0] lane [0:LG];
  logic [XLEN-1:0] perm;
  rec_flags_t      nxt_flags;

  grev_ctl_sel #(.XLEN(XLEN)) u_ctl (
    .ctl_reg  (ctl_reg),
    .imm      (imm),
    .imm_sel  (imm_sel),
    .word_mode(word_mode),
    .k        (k)
  );

  assign src_eff = word_mode ? {{HALF{1'b0}}, src[HALF-1:0]} : src;
  assign lane[0] = src_eff;

  for (genvar s = 0; s < LG; s++) begin : g_stage
    grev_stage #(.W(XLEN), .S(s)) u_stage (
      .din (lane[s]),
      .en  (k[s]),
      .dout(lane[s+1])
    );
  end

  assign perm = lane[LG];

  grev_flags #(.XLEN(XLEN)) u_flags (
    .value (perm),
    .record(record),
    .flags (nxt_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= perm;
        out_flags <= nxt_flags;
      end
    end
  end

  a_r1_full_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !word_mode |=> $countones(result) == $countones($past(src)));

  a_r4_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && word_mode |=> result[XLEN-1:HALF] == '0);

  a_r4_word_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && word_mode |=>
      $countones(result) == $countones($past(src[HALF-1:0])));

  a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(out_flags));

  a_r7_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !record |=> out_flags == 3'b000);

  a_r7_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && record |=> $countones(out_flags) == 1);
endmodule

// File: tb/grev_permuter_test.sv
module grev_permuter_test;
  localparam int XLEN = 64;
  localparam int LG   = 6;
  localparam int HALF = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [XLEN-1:0] src = '0;
  logic [XLEN-1:0] ctl_reg = '0;
  logic [5:0]      imm = '0;
  logic            imm_sel = 1'b0;
  logic            word_mode = 1'b0;
  logic            record = 1'b0;
  logic            out_valid;
  logic [XLEN-1:0] result;
  logic [2:0]      out_flags;

  int total = 0;
  int bad = 0;

  grev_permuter #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
    .ctl_reg(ctl_reg), .imm(imm), .imm_sel(imm_sel),
    .word_mode(word_mode), .record(record), .out_valid(out_valid),
    .result(result), .out_flags(out_flags)
  );

  always #4 clk = ~clk;

  function automatic logic [XLEN-1:0] model(logic [XLEN-1:0] s, int kk, bit wm);
    logic [XLEN-1:0] r = '0;
    int width = wm ? HALF : XLEN;
    int kx = wm ? (kk % HALF) : (kk % XLEN);
    for (int i = 0; i < width; i++) r[i] = s[i ^ kx];
    return r;
  endfunction

  function automatic logic [2:0] flag_model(logic [XLEN-1:0] r, bit rec);
    if (!rec) return 3'b000;
    if (r == '0) return 3'b001;
    if (r[XLEN-1]) return 3'b100;
    return 3'b010;
  endfunction

  task automatic check(string tag, logic [XLEN+3:0] got, logic [XLEN+3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Presents one operation and checks it one cycle later.
  task automatic run_op(string tag, logic [XLEN-1:0] s, logic [XLEN-1:0] cr,
                        logic [5:0] im, bit is, bit wm, bit rec, int kk);
    logic [XLEN-1:0] er;
    @(negedge clk);
    src = s; ctl_reg = cr; imm = im; imm_sel = is; word_mode = wm;
    record = rec; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    er = model(s, kk, wm);
    check(tag, {out_valid, out_flags, result}, {1'b1, flag_model(er, rec), er});
  endtask

  logic [XLEN-1:0] pats [4];
  logic [XLEN-1:0] held;

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'h8000_0000_0000_0001;
    pats[2] = 64'hF0E1_D2C3_B4A5_9687;
    pats[3] = 64'h0;

    repeat (3) @(negedge clk);
    check("R8 reset", {out_valid, out_flags, result}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", {out_valid, out_flags, result}, '0);

    // R9 corner cases.
    run_op("R9 identity", 64'hDEAD_BEEF_0BAD_F00D, 64'h0, 6'd0, 0, 0, 0, 0);
    begin
      logic [XLEN-1:0] rv;
      for (int i = 0; i < XLEN; i++) rv[i] = pats[2][XLEN-1-i];
      @(negedge clk);
      src = pats[2]; ctl_reg = 64'h3F; imm_sel = 0; word_mode = 0;
      record = 0; in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      check("R9 full reversal", {4'b1000, result}, {4'b1000, rv});
    end

    // R1 and R2: register form, garbage above the control bits and in imm.
    for (int p = 0; p < 4; p++)
      for (int kk = 0; kk < XLEN; kk++)
        run_op("R1 R2 reg form", pats[p],
               {~pats[p][XLEN-1:LG], 6'(kk)}, 6'(~kk), 0, 0, kk[0], kk);

    // R3: immediate form, ctl_reg holds an unrelated value.
    for (int p = 0; p < 4; p++)
      for (int kk = 0; kk < XLEN; kk++)
        run_op("R3 imm form", pats[p], {58'h2AA_AAAA_5555_5555, 6'(~kk)},
               6'(kk), 1, 0, kk[1], kk);

    // R4: word mode, register form, bit 5 of the control set as garbage.
    for (int p = 0; p < 4; p++)
      for (int kk = 0; kk < HALF; kk++)
        run_op("R4 word reg", pats[p] | 64'hA5A5_0000_0000_0000,
               {58'h3FF_FFFF_FFFF_FFFF, 6'(kk) | 6'h20}, 6'h00, 0, 1, 1, kk);

    // R5: word mode, immediate form, imm[5] set and must be ignored.
    for (int p = 0; p < 4; p++)
      for (int kk = 0; kk < HALF; kk++)
        run_op("R5 word imm", ~pats[p], 64'h1F, 6'(kk) | 6'h20, 1, 1, 1, kk);

    // R7: each flag outcome.
    run_op("R7 zero", 64'h0, 64'h5, 6'd0, 0, 0, 1, 5);
    run_op("R7 neg", 64'h1, 64'h3F, 6'd0, 0, 0, 1, 63);
    run_op("R7 pos", 64'h8000_0000_0000_0000, 64'h3F, 6'd0, 0, 0, 1, 63);
    run_op("R7 no record", 64'h8000_0000_0000_0000, 64'h0, 6'd0, 0, 0, 0, 0);

    // R6: no strobe means no new output and the old value is kept.
    run_op("R6 load", 64'h1234_5678_9ABC_DEF0, 64'h4, 6'd0, 0, 0, 1, 4);
    held = model(64'h1234_5678_9ABC_DEF0, 4, 0);
    @(negedge clk);
    src = 64'hFFFF_FFFF_FFFF_FFFF; ctl_reg = 64'h0; record = 0; in_valid = 0;
    @(negedge clk);
    check("R6 hold", {out_valid, out_flags, result},
          {1'b0, flag_model(held, 1), held});
    @(negedge clk);
    check("R6 hold again", {out_valid, result}, {1'b0, held});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule